// File: doc/BRIEF.md
# Integer ALU with Sign/Zero Flags and Branch Resolution

This block is the integer execute slice of a simple processor pipeline. Each cycle in which `op_valid` is high it takes two 32-bit operands and a 4-bit operation code. It produces a registered result one cycle later, together with a one-cycle `res_valid` strobe. The second operand is whatever the pipeline selected, either a register value or an immediate. The supported operations are add, subtract, multiply, signed divide, signed remainder, one's complement, three bitwise operations and their whole-result negations, and three shifts.

The block keeps a two-bit condition register: negative in bit 1 and zero in bit 0. Arithmetic operations update it. Bitwise and shift operations leave it alone unless the build parameter `LOGIC_SETS_FLAGS` is set. A side port from the load unit also updates the register from a loaded word. A combinational branch test compares a 3-bit condition selector with the stored flags and drives `br_taken`.

Reset is asynchronous and active low on assertion, and is released through a two-stage synchronizer.

Top module: `intalu_nzb`

## Requirements
- R1: When `op_valid` is high at a rising edge, `result` takes the operation's value at that edge and `res_valid` is high for exactly the following cycle. When `op_valid` is low, `result` holds and `res_valid` is low. Codes are ADD=0, SUB=1, MUL=2, DIV=3, MOD=4, CPL=5, OR=6, XOR=7, AND=8, NOR=9, XNOR=10, NAND=11, SLL=12, SRL=13, SRA=14. Add, subtract and multiply return the low 32 bits.
- R2: DIV and MOD treat the operands as signed and truncate toward zero, so the remainder takes the dividend's sign. A zero divisor gives all ones for DIV and zero for MOD. The most negative value divided by minus one gives the most negative value as quotient and zero as remainder.
- R3: CPL returns the bitwise complement of operand A, and operand B has no effect on it.
- R4: NOR returns NOT(A OR B), XNOR returns NOT(A XOR B), and NAND returns NOT(A AND B). OR, XOR and AND return the plain bitwise values.
- R5: SLL and SRL shift operand A and fill the vacated positions with zeros. SRA fills the upper positions with copies of bit 31. Only bits [4:0] of operand B give the shift amount.
- R6: ADD, SUB, MUL, DIV, MOD and CPL write the flags from the result: bit 1 (N) is set when result bit 31 is 1, and bit 0 (Z) is set when the result is zero. N and Z are never both set.
- R7: With `LOGIC_SETS_FLAGS`=0 (the default), the bitwise and shift operations leave the flags unchanged.
- R8: A load strobe `ld_valid` without `op_valid` writes N and Z from `ld_data` at that edge. If `op_valid` is also high, the load is ignored for the flags. With neither strobe, the flags hold.
- R9: `br_cond` codes are LT=0 (N), LE=1 (N or Z), EQ=2 (Z), GE=3 (not N), GT=4 (neither N nor Z), NE=5 (not Z), ALWAYS=6 (1) and NEVER=7 (0). `br_taken` follows the stored flags combinationally.
- R10: During reset and until its synchronized release, `result` is zero, `res_valid` is low and the flags are 00.
- R11: Operation code 15 returns a zero result and never changes the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation issue strobe |
| op_code | input | 4 | Operation selector |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B (register or immediate) |
| ld_valid | input | 1 | Loaded word present |
| ld_data | input | 32 | Loaded word for flag update |
| br_cond | input | 3 | Branch condition selector |
| result | output | 32 | Registered operation result |
| res_valid | output | 1 | Result strobe, one cycle |
| flags | output | 2 | {N, Z} condition register |
| br_taken | output | 1 | Branch condition satisfied |

## Verification
Arithmetic is driven with positive, negative and zero results, so each flag pattern is produced and a swapped N/Z bit shows up. Multiply is also driven with a product that wraps to zero. Division is tried with a negative dividend, a zero divisor and the single overflowing pair, which separate truncating division from floor division and check the guard values. The bitwise cases use a nonzero operand B against complement, and mixed-polarity results with flags preset to negative, so an accidental flag update or an operand-negation variant of the negated forms gives a different word. Shifts use amounts with bit 5 set and sign-bit sources, and the branch test is swept over all eight selectors against each reachable flag pattern.

// File: rtl/intalu_pkg.sv
package intalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_MOD  = 4'd4,
    OP_CPL  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_AND  = 4'd8,
    OP_NOR  = 4'd9,
    OP_XNOR = 4'd10,
    OP_NAND = 4'd11,
    OP_SLL  = 4'd12,
    OP_SRL  = 4'd13,
    OP_SRA  = 4'd14,
    OP_RSVD = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    BC_LT  = 3'd0,
    BC_LE  = 3'd1,
    BC_EQ  = 3'd2,
    BC_GE  = 3'd3,
    BC_GT  = 3'd4,
    BC_NE  = 3'd5,
    BC_AL  = 3'd6,
    BC_NV  = 3'd7
  } br_cond_e;

  localparam int FLAG_N = 1;
  localparam int FLAG_Z = 0;

  function automatic logic is_arith_op(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) ||
           (op == OP_DIV) || (op == OP_MOD) || (op == OP_CPL);
  endfunction

  function automatic logic is_logic_op(input alu_op_e op);
    return (op >= OP_OR) && (op <= OP_SRA);
  endfunction

endpackage

// File: rtl/intalu_arith.sv
module intalu_arith
  import intalu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] quo;
  logic [W-1:0] rem;

  always_comb begin
    if (b == '0) begin
      quo = ALL_ONES;
      rem = '0;
    end else if ((a == MOST_NEG) && (b == ALL_ONES)) begin
      quo = MOST_NEG;
      rem = '0;
    end else begin
      quo = $signed(a) / $signed(b);
      rem = $signed(a) % $signed(b);
    end
  end

  always_comb begin
    unique case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_DIV:  res = quo;
      OP_MOD:  res = rem;
      OP_CPL:  res = ~a;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/intalu_shift.sv
module intalu_shift #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   src,
  input  logic [SHW-1:0] amt,
  input  logic           to_left,
  input  logic           arith,
  output logic [W-1:0]   dst
);

  logic [W-1:0] stage [SHW+1];
  logic [W-1:0] flipped_in;
  logic [W-1:0] flipped_out;
  logic         fill;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      flipped_in[i] = src[W-1-i];
    end
  end

  assign fill     = arith & ~to_left & src[W-1];
  assign stage[0] = to_left ? flipped_in : src;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = amt[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      flipped_out[i] = stage[SHW][W-1-i];
    end
  end

  assign dst = to_left ? flipped_out : stage[SHW];

endmodule

// File: rtl/intalu_logic.sv
module intalu_logic
  import intalu_pkg::*;
#(
  parameter int W = 32,
  parameter bit LOGIC_SETS_FLAGS = 1'b0,
  localparam int SHW = $clog2(W)
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           sets_flags
);

  logic [W-1:0] sh_out;
  logic         sh_left;
  logic         sh_arith;

  assign sh_left  = (op == OP_SLL);
  assign sh_arith = (op == OP_SRA);

  intalu_shift #(.W(W)) u_shift (
    .src     (a),
    .amt     (b[SHW-1:0]),
    .to_left (sh_left),
    .arith   (sh_arith),
    .dst     (sh_out)
  );

  always_comb begin
    unique case (op)
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_AND:  res = a & b;
      OP_NOR:  res = ~(a | b);
      OP_XNOR: res = ~(a ^ b);
      OP_NAND: res = ~(a & b);
      OP_SLL,
      OP_SRL,
      OP_SRA:  res = sh_out;
      default: res = '0;
    endcase
  end

  if (LOGIC_SETS_FLAGS) begin : g_flag_on
    assign sets_flags = is_logic_op(op);
  end else begin : g_flag_off
    assign sets_flags = 1'b0;
  end

endmodule

// File: rtl/intalu_flags.sv
module intalu_flags
  import intalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_busy,
  input  logic         op_upd,
  input  logic [W-1:0] op_val,
  input  logic         ld_upd,
  input  logic [W-1:0] ld_val,
  output logic [1:0]   flags_q
);

  logic [1:0] flags_d;
  logic       flags_en;

  always_comb begin
    flags_d  = flags_q;
    flags_en = 1'b0;
    if (op_upd) begin
      flags_en        = 1'b1;
      flags_d[FLAG_N] = op_val[W-1];
      flags_d[FLAG_Z] = (op_val == '0);
    end else if (ld_upd && !op_busy) begin
      flags_en        = 1'b1;
      flags_d[FLAG_N] = ld_val[W-1];
      flags_d[FLAG_Z] = (ld_val == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= 2'b00;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/intalu_cond.sv
module intalu_cond
  import intalu_pkg::*;
(
  input  br_cond_e   cond,
  input  logic [1:0] flg,
  output logic       taken
);

  logic n;
  logic z;

  assign n = flg[FLAG_N];
  assign z = flg[FLAG_Z];

  always_comb begin
    unique case (cond)
      BC_LT:   taken = n;
      BC_LE:   taken = n | z;
      BC_EQ:   taken = z;
      BC_GE:   taken = ~n;
      BC_GT:   taken = ~n & ~z;
      BC_NE:   taken = ~z;
      BC_AL:   taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/intalu_nzb.sv
module intalu_nzb
  import intalu_pkg::*;
#(
  parameter int W = 32,
  parameter bit LOGIC_SETS_FLAGS = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         ld_valid,
  input  logic [W-1:0] ld_data,
  input  logic [2:0]   br_cond,
  output logic [W-1:0] result,
  output logic         res_valid,
  output logic [1:0]   flags,
  output logic         br_taken
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_q = rst_pipe[SYNC_STAGES-1];

  alu_op_e      op;
  logic [W-1:0] ar_res;
  logic [W-1:0] lg_res;
  logic         lg_sets;
  logic         arith_sel;
  logic [W-1:0] res_d;
  logic         res_en;
  logic         vld_d;
  logic         flag_upd;

  assign op = alu_op_e'(op_code);

  intalu_arith #(.W(W)) u_arith (
    .op  (op),
    .a   (opa),
    .b   (opb),
    .res (ar_res)
  );

  intalu_logic #(.W(W), .LOGIC_SETS_FLAGS(LOGIC_SETS_FLAGS)) u_logic (
    .op         (op),
    .a          (opa),
    .b          (opb),
    .res        (lg_res),
    .sets_flags (lg_sets)
  );

  always_comb begin
    arith_sel = is_arith_op(op);
    res_d     = arith_sel ? ar_res : lg_res;
    res_en    = op_valid;
    vld_d     = op_valid;
    flag_upd  = op_valid & (arith_sel | lg_sets);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      result    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= vld_d;
      if (res_en) begin
        result <= res_d;
      end
    end
  end

  intalu_flags #(.W(W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_q),
    .op_busy (op_valid),
    .op_upd  (flag_upd),
    .op_val  (res_d),
    .ld_upd  (ld_valid),
    .ld_val  (ld_data),
    .flags_q (flags)
  );

  intalu_cond u_cond (
    .cond  (br_cond_e'(br_cond)),
    .flg   (flags),
    .taken (br_taken)
  );

endmodule

// File: rtl/intalu_nzb_chk.sv
module intalu_nzb_chk
  import intalu_pkg::*;
#(
  parameter int W = 32,
  parameter bit LOGIC_SETS_FLAGS = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [3:0]   op_code,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         ld_valid,
  input logic [2:0]   br_cond,
  input logic [W-1:0] result,
  input logic         res_valid,
  input logic [1:0]   flags,
  input logic         br_taken
);

  logic logic_code;
  assign logic_code = (op_code >= 4'd6) && (op_code <= 4'd14);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid); // R1

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid); // R1

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(result)); // R1

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd0) |=> (result == $past(opa + opb))); // R1

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd3 && opb == '0) |=> (result == {W{1'b1}})); // R2

  AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    flags != 2'b11); // R6

  AST_LOGIC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!LOGIC_SETS_FLAGS && op_valid && logic_code) |=> $stable(flags)); // R7

  AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !ld_valid) |=> $stable(flags)); // R8

  AST_BR_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (br_cond == 3'd6) |-> br_taken); // R9

  AST_BR_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (br_cond == 3'd7) |-> !br_taken); // R9

  AST_RSVD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd15) |=> ($stable(flags) && result == '0)); // R11

endmodule

bind intalu_nzb intalu_nzb_chk #(.W(W), .LOGIC_SETS_FLAGS(LOGIC_SETS_FLAGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .opa       (opa),
  .opb       (opb),
  .ld_valid  (ld_valid),
  .br_cond   (br_cond),
  .result    (result),
  .res_valid (res_valid),
  .flags     (flags),
  .br_taken  (br_taken)
);

// File: tb/intalu_nzb_bench.sv
module intalu_nzb_bench;
  import intalu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [31:0] opa;
  logic [31:0] opb;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic [2:0]  br_cond;
  logic [31:0] result;
  logic        res_valid;
  logic [1:0]  flags;
  logic        br_taken;

  int n_checks = 0;
  int n_bad    = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  intalu_nzb u_intalu_nzb (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opa       (opa),
    .opb       (opb),
    .ld_valid  (ld_valid),
    .ld_data   (ld_data),
    .br_cond   (br_cond),
    .result    (result),
    .res_valid (res_valid),
    .flags     (flags),
    .br_taken  (br_taken)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input alu_op_e op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = op;
    opa      = a;
    opb      = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] d);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_data  = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic op_chk(input string tag, input alu_op_e op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] exp_res,
                        input logic [1:0] exp_flg);
    run_op(op, a, b);
    chk({tag, " result"}, result, exp_res);
    chk({tag, " flags"}, {30'd0, flags}, {30'd0, exp_flg});
  endtask

  function automatic logic br_expect(input logic [2:0] c, input logic [1:0] f);
    logic n;
    logic z;
    n = f[1];
    z = f[0];
    case (c)
      3'd0:    return n;
      3'd1:    return n || z;
      3'd2:    return z;
      3'd3:    return !n;
      3'd4:    return !n && !z;
      3'd5:    return !z;
      3'd6:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_reset;
    chk("R10 result at reset", result, 32'd0);
    chk("R10 res_valid at reset", {31'd0, res_valid}, 32'd0);
    chk("R10 flags at reset", {30'd0, flags}, 32'd0);
  endtask

  task automatic t_valid;
    run_op(OP_ADD, 32'd5, 32'd7);
    chk("R1 valid strobe", {31'd0, res_valid}, 32'd1);
    chk("R1 add result", result, 32'd12);
    @(negedge clk);
    chk("R1 strobe drops", {31'd0, res_valid}, 32'd0);
    chk("R1 result held", result, 32'd12);
  endtask

  task automatic t_arith;
    op_chk("R1 R6 add pos", OP_ADD, 32'd5, 32'd7, 32'd12, 2'b00);
    op_chk("R1 R6 sub neg", OP_SUB, 32'd3, 32'd10, 32'hFFFF_FFF9, 2'b10);
    op_chk("R1 R6 sub zero", OP_SUB, 32'd4, 32'd4, 32'd0, 2'b01);
    op_chk("R1 mul wrap", OP_MUL, 32'h0001_0000, 32'h0001_0000, 32'd0, 2'b01);
    op_chk("R1 mul neg", OP_MUL, 32'hFFFF_FFFD, 32'd7, 32'hFFFF_FFEB, 2'b10);
  endtask

  task automatic t_divmod;
    op_chk("R2 div trunc", OP_DIV, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFD, 2'b10);
    op_chk("R2 mod sign", OP_MOD, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFF, 2'b10);
    op_chk("R2 mod pos", OP_MOD, 32'd7, 32'd3, 32'd1, 2'b00);
    op_chk("R2 div by zero", OP_DIV, 32'd9, 32'd0, 32'hFFFF_FFFF, 2'b10);
    op_chk("R2 mod by zero", OP_MOD, 32'd9, 32'd0, 32'd0, 2'b01);
    op_chk("R2 div overflow", OP_DIV, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 2'b10);
    op_chk("R2 mod overflow", OP_MOD, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 2'b01);
  endtask

  task automatic t_cpl;
    op_chk("R3 cpl to zero", OP_CPL, 32'hFFFF_FFFF, 32'h1234_5678, 32'd0, 2'b01);
    op_chk("R3 cpl ignores b", OP_CPL, 32'h0000_00FF, 32'hFFFF_FFFF, 32'hFFFF_FF00, 2'b10);
  endtask

  task automatic t_logic;
    do_load(32'h8000_0000);
    chk("R8 flags from load", {30'd0, flags}, 32'd2);
    op_chk("R4 R7 or", OP_OR, 32'hF0F0_0000, 32'h0000_0F0F, 32'hF0F0_0F0F, 2'b10);
    op_chk("R4 R7 nor", OP_NOR, 32'hF0F0_0000, 32'h0000_0F0F, 32'h0F0F_F0F0, 2'b10);
    op_chk("R4 R7 xor", OP_XOR, 32'hFF00_FF00, 32'h0FF0_0FF0, 32'hF0F0_F0F0, 2'b10);
    op_chk("R4 R7 xnor", OP_XNOR, 32'hFF00_FF00, 32'h0FF0_0FF0, 32'h0F0F_0F0F, 2'b10);
    op_chk("R4 R7 and", OP_AND, 32'hFF00_FF00, 32'h0FF0_0FF0, 32'h0F00_0F00, 2'b10);
    op_chk("R4 R7 nand", OP_NAND, 32'hFF00_FF00, 32'h0FF0_0FF0, 32'hF0FF_F0FF, 2'b10);
    op_chk("R4 R7 and zero", OP_AND, 32'hF000_0000, 32'h0F00_0000, 32'd0, 2'b10);
  endtask

  task automatic t_shift;
    op_chk("R5 R7 sll 31", OP_SLL, 32'd1, 32'd31, 32'h8000_0000, 2'b10);
    op_chk("R5 sll low bits", OP_SLL, 32'd1, 32'h0000_0021, 32'd2, 2'b10);
    op_chk("R5 srl zero fill", OP_SRL, 32'h8000_0000, 32'd4, 32'h0800_0000, 2'b10);
    op_chk("R5 sra sign fill", OP_SRA, 32'h8000_0000, 32'd4, 32'hF800_0000, 2'b10);
    op_chk("R5 sra positive", OP_SRA, 32'h4000_0000, 32'd4, 32'h0400_0000, 2'b10);
    op_chk("R5 sra max", OP_SRA, 32'h8000_0000, 32'h0000_003F, 32'hFFFF_FFFF, 2'b10);
    op_chk("R5 srl by zero", OP_SRL, 32'h0000_0000, 32'h0000_0020, 32'd0, 2'b10);
  endtask

  task automatic t_rsvd;
    op_chk("R11 unused code", OP_RSVD, 32'h1234_5678, 32'h1111_1111, 32'd0, 2'b10);
  endtask

  task automatic t_load;
    do_load(32'd0);
    chk("R8 load zero", {30'd0, flags}, 32'd1);
    do_load(32'd5);
    chk("R8 load positive", {30'd0, flags}, 32'd0);
    do_load(32'h8000_0001);
    chk("R8 load negative", {30'd0, flags}, 32'd2);
    @(negedge clk);
    chk("R8 idle hold", {30'd0, flags}, 32'd2);
    @(negedge clk);
    op_valid = 1'b1; op_code = OP_ADD; opa = 32'd1; opb = 32'd1;
    ld_valid = 1'b1; ld_data = 32'd0;
    @(negedge clk);
    op_valid = 1'b0; ld_valid = 1'b0;
    chk("R8 op beats load", {30'd0, flags}, 32'd0);
    do_load(32'hFFFF_0000);
    @(negedge clk);
    op_valid = 1'b1; op_code = OP_XOR; opa = 32'd3; opb = 32'd3;
    ld_valid = 1'b1; ld_data = 32'd0;
    @(negedge clk);
    op_valid = 1'b0; ld_valid = 1'b0;
    chk("R8 R7 load ignored with logic op", {30'd0, flags}, 32'd2);
  endtask

  task automatic t_branch;
    logic [31:0] ld_vals [3];
    ld_vals[0] = 32'd9;
    ld_vals[1] = 32'd0;
    ld_vals[2] = 32'hC000_0000;
    for (int v = 0; v < 3; v++) begin
      do_load(ld_vals[v]);
      for (int c = 0; c < 8; c++) begin
        br_cond = c[2:0];
        #1;
        chk($sformatf("R9 cond %0d flags %b", c, flags), {31'd0, br_taken},
            {31'd0, br_expect(c[2:0], flags)});
      end
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_code  = 4'd0;
    opa      = '0;
    opb      = '0;
    ld_valid = 1'b0;
    ld_data  = '0;
    br_cond  = 3'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_valid();
    t_arith();
    t_divmod();
    t_cpl();
    t_logic();
    t_shift();
    t_rsvd();
    t_load();
    t_branch();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule